// File: doc/BRIEF.md
# Predicated Vector Branch-Condition Evaluator

The block decides whether a vector branch is taken. It walks the elements of a vector one per clock in ascending order. For each element it reads one condition bit and compares it with a requested polarity. A 64-bit predicate mask controls each element. A masked-out element is either skipped, or it has a forced value (zero or one) put in place of its condition bit. Forcing lets software make the test fail on purpose at a chosen element. The mask may come from an integer register or from a condition register; the block sees only the mask bits and treats both sources the same way.

The block has two combining modes. In any-mode, one passing element is enough for the branch to be taken. In all-mode, every tested element must pass. When truncation is enabled, the block also returns a shortened vector length that ends just before the first failing element. A start strobe captures all inputs. When the walk ends, a one-cycle done pulse presents the decision and the length, and both outputs hold their values afterwards.

Top module: `vbranch_eval`

## Requirements
- R1: After reset, `done`, `taken` and `new_len` are all 0.
- R2: If `start` is sampled at a rising edge with `vec_len` = L, `done` is high for exactly one cycle, which follows the (L+1)-th rising edge after the sampling edge. `done` is low in every cycle before that one and in the cycle after it.
- R3: When `zero_en` = 0, an element whose `pred_mask` bit is 0 is not tested. It can neither pass nor fail.
- R4: When `zero_en` = 1 and `force_one` = 0, a masked-out element is tested with a 0 in place of its condition bit.
- R5: When `zero_en` = 1 and `force_one` = 1, a masked-out element is tested with a 1 in place of its condition bit.
- R6: An element passes when its tested bit equals `want_set`: 1 means the bit must be set, 0 means it must be clear. With `all_mode` = 0, `taken` = 1 if at least one tested element passes.
- R7: With `all_mode` = 1, `taken` = 1 only if at least one element was tested and no tested element failed.
- R8: With `vec_len` = 0, `taken` = 0 and `new_len` = 0.
- R9: With `trunc_en` = 1, `new_len` is the index of the lowest-indexed tested element that fails.
- R10: `new_len` equals `vec_len` when `trunc_en` = 0, and also when `trunc_en` = 1 and no tested element fails. This includes the full length of 64.
- R11: `taken` and `new_len` change only at the end of an evaluation. They stay stable while the block is idle.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the inputs and begins an evaluation |
| cond_bits | input | 64 | Condition bit per element, bit i for element i |
| pred_mask | input | 64 | Predicate, bit i enables element i |
| vec_len | input | 7 | Vector length, 0 to 64 |
| want_set | input | 1 | Required polarity of the tested bit |
| zero_en | input | 1 | Substitute a value for masked-out elements instead of skipping them |
| force_one | input | 1 | Substituted value is 1 instead of 0 |
| all_mode | input | 1 | Require all tested elements to pass |
| trunc_en | input | 1 | Truncate the length at the first failure |
| taken | output | 1 | Branch decision |
| new_len | output | 7 | Resulting vector length |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a first failure that comes from a substituted value rather than a real condition bit. A related case is an early masked-out element that would fail if it were tested but is skipped. To reach these, the stimulus uses the same condition pattern with several mask and zeroing combinations, so the truncation point moves between a real failing bit and a forced one. The stimulus also covers the edges of the length range: an empty vector, and a full 64-element vector whose only failure is in the top element.

// File: rtl/vbranch_eval.sv
module vbranch_eval #(
  parameter int MAXL = 64,
  localparam int LW = $clog2(MAXL + 1),
  localparam int IW = $clog2(MAXL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MAXL-1:0] cond_bits,
  input  logic [MAXL-1:0] pred_mask,
  input  logic [LW-1:0]   vec_len,
  input  logic            want_set,
  input  logic            zero_en,
  input  logic            force_one,
  input  logic            all_mode,
  input  logic            trunc_en,
  output logic            taken,
  output logic [LW-1:0]   new_len,
  output logic            done
);

  logic [MAXL-1:0] cond_r, pred_r;
  logic [LW-1:0]   len_r, idx, fail_idx;
  logic            want_r, zero_r, one_r, all_r, trunc_r;
  logic            busy, any_pass, any_fail, any_test;

  wire [IW-1:0] sel    = idx[IW-1:0];
  wire          fin    = busy && (idx == len_r);
  wire          active = pred_r[sel];
  wire          tested = busy && !fin && (active || zero_r);
  wire          bitv   = active ? cond_r[sel] : one_r;
  wire          pass   = (bitv == want_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_r <= '0; pred_r <= '0; len_r <= '0; idx <= '0; fail_idx <= '0;
      want_r <= 1'b0; zero_r <= 1'b0; one_r <= 1'b0; all_r <= 1'b0; trunc_r <= 1'b0;
      busy <= 1'b0; any_pass <= 1'b0; any_fail <= 1'b0; any_test <= 1'b0;
      taken <= 1'b0; new_len <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cond_r <= cond_bits; pred_r <= pred_mask; len_r <= vec_len;
        want_r <= want_set; zero_r <= zero_en; one_r <= force_one;
        all_r <= all_mode; trunc_r <= trunc_en;
        idx <= '0; busy <= 1'b1;
        any_pass <= 1'b0; any_fail <= 1'b0; any_test <= 1'b0;
      end else if (fin) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        taken   <= all_r ? (any_test && !any_fail) : any_pass;
        new_len <= (trunc_r && any_fail) ? fail_idx : len_r;
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (tested) begin
          any_test <= 1'b1;
          if (pass) any_pass <= 1'b1;
          else if (!any_fail) begin
            any_fail <= 1'b1;
            fail_idx <= idx;
          end
        end
      end
    end
  end

  p_len_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> vec_len <= LW'(MAXL));

  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx <= len_r);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_len_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_len <= len_r);

  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len_r == '0) |-> (!taken && new_len == '0));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(taken) && $stable(new_len)));

  p_all_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && all_r && any_fail) |=> !taken);

endmodule

// File: tb/test_vbranch_eval.sv
module test_vbranch_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] cond_bits = '0, pred_mask = '0;
  logic [6:0]  vec_len = '0;
  logic        want_set = 1'b0, zero_en = 1'b0, force_one = 1'b0, all_mode = 1'b0, trunc_en = 1'b0;
  logic        taken, done;
  logic [6:0]  new_len;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  vbranch_eval i_vbranch_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .cond_bits(cond_bits),
    .pred_mask(pred_mask), .vec_len(vec_len), .want_set(want_set),
    .zero_en(zero_en), .force_one(force_one), .all_mode(all_mode),
    .trunc_en(trunc_en), .taken(taken), .new_len(new_len), .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] c, input logic [63:0] p,
                     input int len, input logic w, input logic z, input logic o,
                     input logic a, input logic t, input logic exp_taken, input int exp_len);
    int early;
    @(negedge clk);
    cond_bits = c; pred_mask = p; vec_len = 7'(len);
    want_set = w; zero_en = z; force_one = o; all_mode = a; trunc_en = t;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    early = 0;
    for (int k = 0; k < len; k++) begin
      @(posedge clk); @(negedge clk);
      if (done) early++;
    end
    chk({"R2 no early done ", tag}, early, 0);
    @(posedge clk); @(negedge clk);
    chk({"R2 done ", tag}, done, 1);
    chk({"taken ", tag}, taken, exp_taken);
    chk({"new_len ", tag}, new_len, exp_len);
    @(posedge clk); @(negedge clk);
    chk({"R2 done single ", tag}, done, 0);
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0);
    chk("R1 taken", taken, 0);
    chk("R1 new_len", new_len, 0);
  endtask

  task automatic t_any;
    run("R6 any one pass", 64'h04, 64'hFF, 8, 1, 0, 0, 0, 0, 1, 8);
    run("R6 any none pass", 64'h00, 64'hFF, 8, 1, 0, 0, 0, 0, 0, 8);
    run("R6 polarity clear", 64'hFF, 64'hFF, 8, 0, 0, 0, 0, 0, 0, 8);
  endtask

  task automatic t_all;
    run("R7 all pass", 64'hFF, 64'hFF, 8, 1, 0, 0, 1, 0, 1, 8);
    run("R7 all one fail", 64'hFE, 64'hFF, 8, 1, 0, 0, 1, 0, 0, 8);
    run("R7 all nothing tested", 64'hFF, 64'h0, 4, 1, 0, 0, 1, 1, 0, 4);
  endtask

  task automatic t_mask;
    run("R3 skip masked", 64'hFE, 64'hFE, 8, 1, 0, 0, 1, 1, 1, 8);
    run("R4 zero masked", 64'hFF, 64'hFE, 8, 1, 1, 0, 1, 1, 0, 0);
    run("R5 one masked", 64'hFE, 64'hFE, 8, 1, 1, 1, 1, 1, 1, 8);
    run("R4 zero makes pass clear", 64'hFF, 64'hF7, 8, 0, 1, 0, 0, 1, 1, 0);
  endtask

  task automatic t_trunc;
    logic [63:0] c;
    c = ~((64'd1 << 3) | (64'd1 << 10));
    run("R9 first fail 3", c, '1, 20, 1, 0, 0, 1, 1, 0, 3);
    run("R9 skipped fail moves to 10", c, ~(64'd1 << 3), 20, 1, 0, 0, 1, 1, 0, 10);
    run("R9 forced fail at 1", '1, ~(64'd1 << 1), 20, 1, 1, 0, 1, 1, 0, 1);
    run("R9 polarity clear fail 5", 64'd1 << 5, '1, 12, 0, 0, 0, 0, 1, 1, 5);
    run("R10 trunc off", c, '1, 20, 1, 0, 0, 1, 0, 0, 20);
  endtask

  task automatic t_bounds;
    run("R8 empty any", '1, '1, 0, 1, 0, 0, 0, 1, 0, 0);
    run("R8 empty all", '1, '1, 0, 1, 0, 0, 1, 1, 0, 0);
    run("R10 full 64 pass", '1, '1, 64, 1, 0, 0, 1, 1, 1, 64);
    run("R9 full 64 top fail", ~(64'd1 << 63), '1, 64, 1, 0, 0, 1, 1, 0, 63);
  endtask

  task automatic t_hold;
    run("R11 setup", 64'h1, 64'hFF, 6, 1, 0, 0, 1, 1, 0, 1);
    cond_bits = '1; pred_mask = '0; vec_len = 7'd9; all_mode = 1'b0; trunc_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 taken held", taken, 0);
    chk("R11 new_len held", new_len, 1);
    chk("R11 done low", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_any();
    t_all();
    t_mask();
    t_trunc();
    t_bounds();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule